// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block sits between the receive shift register of a 16550-class serial port and the processor-facing register file. Each completed character arrives as a one-cycle strobe carrying the data byte and three error marks: parity, framing and break. The block keeps up to sixteen characters in arrival order. Each character's error marks are stored beside it, so the processor sees the marks of a character only when that character is at the head of the queue.

The block raises a fill-threshold flag that the interrupt logic uses as the data-available source. It also raises an inactivity flag when characters have waited unread for four character times. Its remaining outputs are the receive-side line status bits: data present, overrun, the head error marks and an aggregate error flag. A write to the queue control register selects the threshold and can empty the queue. Such a write acts only when its enable bit (bit 0) is set. A separate one-cycle tick, pulsing once per character time, drives the inactivity timer.

Top module: `uart_rxq`

## Requirements
- R1: Characters leave in arrival order. Up to DEPTH (16) characters are held. `rx_byte` shows the head character, and `rdy` is 1 exactly while at least one character is held.
- R2: `hd_perr`, `hd_ferr` and `hd_brk` show the marks stored with the head character. All three are 0 while the queue is empty.
- R3: `any_err` is 1 while any held character carries at least one error mark. It drops once the last such character has been read.
- R4: A control write with `ctl_data[0]`=0 changes nothing: neither the threshold nor the queue contents.
- R5: A control write with `ctl_data[0]`=1 and `ctl_data[1]`=1 empties the queue. If a character strobe arrives in the same cycle, that character is discarded as well.
- R6: A control write with `ctl_data[0]`=1 loads the threshold from `ctl_data[7:6]`: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 characters. After reset the threshold is 1.
- R7: `trig` is 1 while the fill level is at or above the threshold, and it falls as soon as the level drops below it.
- R8: `tmo` rises once at least one character is held and TMO_CHARS (4) ticks of `char_tick` have elapsed since the timer last restarted.
- R9: A new character, a read of a held character, or a flush restarts the timer. A read therefore clears `tmo` by the next cycle.
- R10: A strobe that arrives while all DEPTH places are full is discarded, leaves the held characters unchanged and sets `ovr`. `ovr` stays set until `stat_rd` is pulsed. If a new overrun coincides with `stat_rd`, the set wins.
- R11: `rd_stb` while the queue is empty has no effect.
- R12: A character strobe and a read in the same cycle on a non-full queue both take effect: the head advances and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Character completed in the shift register |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error mark of the character |
| in_ferr | input | 1 | Framing error mark of the character |
| in_brk | input | 1 | Break mark of the character |
| rd_stb | input | 1 | Processor read of the receive buffer |
| stat_rd | input | 1 | Processor read of the line status |
| ctl_wr | input | 1 | Queue control register write |
| ctl_data | input | 8 | Queue control write data |
| char_tick | input | 1 | One pulse per character time |
| rx_byte | output | 8 | Head character (0 when empty) |
| rdy | output | 1 | Data present |
| ovr | output | 1 | Overrun flag |
| hd_perr | output | 1 | Parity mark of the head character |
| hd_ferr | output | 1 | Framing mark of the head character |
| hd_brk | output | 1 | Break mark of the head character |
| any_err | output | 1 | Some held character has an error mark |
| trig | output | 1 | Fill level at or above the threshold |
| tmo | output | 1 | Character timeout |

## Verification
Three pairs of actions can fall in the same cycle. An arriving character can meet a processor read, which tests the fill level and pointers. An arriving character can meet a flushing control write, which tests which action wins. A character striking a full queue can meet a status read, which tests the overrun flag. The bench drives each pair in the same cycle. It judges the outcome afterwards at the outputs: it reads out the remaining characters in order, checks that `rdy` falls on a flush, and checks that `ovr` is still set after its own status read.

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_CHARS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          in_brk,
  input  logic          rd_stb,
  input  logic          stat_rd,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic          char_tick,
  output logic [DW-1:0] rx_byte,
  output logic          rdy,
  output logic          ovr,
  output logic          hd_perr,
  output logic          hd_ferr,
  output logic          hd_brk,
  output logic          any_err,
  output logic          trig,
  output logic          tmo
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 3;
  localparam int TW = $clog2(TMO_CHARS + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, ecnt, lvl;
  logic [1:0]    lvl_sel;
  logic [TW-1:0] tcnt;
  logic          ovr_q;

  wire flush    = ctl_wr & ctl_data[0] & ctl_data[1];
  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(DEPTH));
  wire push     = in_vld & ~full & ~flush;
  wire pop      = rd_stb & ~empty & ~flush;
  wire in_err   = in_perr | in_ferr | in_brk;
  wire [EW-1:0] head = mem[rp];
  wire head_err = |head[EW-1:DW];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= {in_brk, in_ferr, in_perr, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
    end else if (flush) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ecnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt  <= cnt + CW'(push) - CW'(pop);
      ecnt <= ecnt + CW'(push & in_err) - CW'(pop & head_err);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      lvl_sel <= 2'b00;
    else if (ctl_wr && ctl_data[0])  lvl_sel <= ctl_data[7:6];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         ovr_q <= 1'b0;
    else if (in_vld && full && !flush)  ovr_q <= 1'b1;
    else if (stat_rd)                   ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush || push || pop || empty)
      tcnt <= '0;
    else if (char_tick && tcnt != TW'(TMO_CHARS))
      tcnt <= tcnt + 1'b1;
  end

  always_comb
    case (lvl_sel)
      2'b00:   lvl = CW'(1);
      2'b01:   lvl = CW'(DEPTH / 4);
      2'b10:   lvl = CW'(DEPTH / 2);
      default: lvl = CW'(DEPTH - 2);
    endcase

  assign rx_byte = empty ? '0 : head[DW-1:0];
  assign hd_perr = ~empty & head[DW];
  assign hd_ferr = ~empty & head[DW+1];
  assign hd_brk  = ~empty & head[DW+2];
  assign rdy     = ~empty;
  assign ovr     = ovr_q;
  assign any_err = (ecnt != '0);
  assign trig    = (cnt >= lvl);
  assign tmo     = ~empty & (tcnt == TW'(TMO_CHARS));
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_vld,
  input logic                       rd_stb,
  input logic                       stat_rd,
  input logic                       ctl_wr,
  input logic [7:0]                 ctl_data,
  input logic                       rdy,
  input logic                       ovr,
  input logic                       hd_perr,
  input logic                       hd_ferr,
  input logic                       hd_brk,
  input logic                       tmo,
  input logic [$clog2(DEPTH):0]     cnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  wire flush = ctl_wr & ctl_data[0] & ctl_data[1];
  wire full  = (cnt == CW'(DEPTH));

  AST_RDY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) rdy == (cnt != '0)); // R1
  AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !rdy |-> !(hd_perr || hd_ferr || hd_brk)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !rdy); // R5
  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) tmo |-> rdy); // R8
  AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n) (rdy && rd_stb) |=> !tmo); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && full && !flush) |=> ovr); // R10
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && full && !flush && !rd_stb) |=> $stable(cnt)); // R10
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !(in_vld && full && !flush)) |=> !ovr); // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (!rdy && rd_stb && !in_vld) |=> !rdy); // R11
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n) (rdy && rd_stb && in_vld && !flush && !full) |=> $stable(cnt)); // R12
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rd_stb(rd_stb), .stat_rd(stat_rd),
  .ctl_wr(ctl_wr), .ctl_data(ctl_data), .rdy(rdy), .ovr(ovr), .hd_perr(hd_perr),
  .hd_ferr(hd_ferr), .hd_brk(hd_brk), .tmo(tmo), .cnt(cnt)
);

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 0, in_perr = 0, in_ferr = 0, in_brk = 0;
  logic rd_stb = 0, stat_rd = 0, ctl_wr = 0, char_tick = 0;
  logic [7:0] in_data = '0, ctl_data = '0, rx_byte;
  logic rdy, ovr, hd_perr, hd_ferr, hd_brk, any_err, trig, tmo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rxq u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_perr(in_perr),
    .in_ferr(in_ferr), .in_brk(in_brk), .rd_stb(rd_stb), .stat_rd(stat_rd),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .char_tick(char_tick), .rx_byte(rx_byte),
    .rdy(rdy), .ovr(ovr), .hd_perr(hd_perr), .hd_ferr(hd_ferr), .hd_brk(hd_brk),
    .any_err(any_err), .trig(trig), .tmo(tmo)
  );

  // {brk, ferr, perr, data}
  localparam logic [10:0] VEC [6] = '{
    {3'b000, 8'h41}, {3'b001, 8'h5A}, {3'b010, 8'h00},
    {3'b100, 8'hFF}, {3'b000, 8'hC3}, {3'b011, 8'h7E}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [10:0] e, input logic rd, input logic sr,
                     input logic cw, input logic [7:0] cd, input logic tk);
    in_vld = v; {in_brk, in_ferr, in_perr, in_data} = e;
    rd_stb = rd; stat_rd = sr; ctl_wr = cw; ctl_data = cd; char_tick = tk;
    @(negedge clk);
    in_vld = 0; rd_stb = 0; stat_rd = 0; ctl_wr = 0; char_tick = 0;
  endtask

  task automatic push(input logic [10:0] e); cyc(1, e, 0, 0, 0, 8'h00, 0); endtask
  task automatic pop();                      cyc(0, '0, 1, 0, 0, 8'h00, 0); endtask
  task automatic ctl(input logic [7:0] d);   cyc(0, '0, 0, 0, 1, d, 0);     endtask
  task automatic tick();                     cyc(0, '0, 0, 0, 0, 8'h00, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdy", rdy, 0);
    chk("R10 reset ovr", ovr, 0);
    chk("R8 reset tmo", tmo, 0);
    chk("R3 reset any_err", any_err, 0);
    chk("R6 reset level 1, empty trig", trig, 0);

    for (int i = 0; i < 6; i++) push(VEC[i]);
    chk("R6 level 1 trig", trig, 1);
    for (int i = 0; i < 6; i++) begin
      logic ae = 0;
      for (int j = i; j < 6; j++) ae |= |VEC[j][10:8];
      chk("R1 order data", rx_byte, VEC[i][7:0]);
      chk("R2 head flags", {hd_brk, hd_ferr, hd_perr}, VEC[i][10:8]);
      chk("R3 any_err", any_err, ae);
      pop();
    end
    chk("R1 drained rdy", rdy, 0);
    chk("R2 empty flags", {hd_brk, hd_ferr, hd_perr}, 0);

    pop();
    chk("R11 empty read rdy", rdy, 0);
    push({3'b000, 8'h99});
    chk("R11 after empty read data", rx_byte, 8'h99);
    pop();

    for (int i = 0; i < 3; i++) push({3'b000, 8'(8'h10 + i)});
    ctl(8'h02);
    chk("R4 gated flush rdy", rdy, 1);
    chk("R4 gated flush head", rx_byte, 8'h10);
    ctl(8'h03);
    chk("R5 flush rdy", rdy, 0);
    push({3'b001, 8'h20});
    cyc(1, {3'b000, 8'h21}, 0, 0, 1, 8'h03, 0);
    chk("R5 flush beats push", rdy, 0);
    chk("R3 flush clears any_err", any_err, 0);

    ctl(8'h41);
    for (int i = 0; i < 3; i++) push({3'b000, 8'(i)});
    chk("R7 level 4 at 3", trig, 0);
    push({3'b000, 8'h03});
    chk("R7 level 4 at 4", trig, 1);
    ctl(8'hC0);
    chk("R4 gated level", trig, 1);
    pop();
    chk("R7 below level", trig, 0);
    ctl(8'h81);
    for (int i = 0; i < 5; i++) push({3'b000, 8'h30});
    chk("R6 level 8 at 8", trig, 1);
    ctl(8'hC1);
    chk("R6 level 14 at 8", trig, 0);
    for (int i = 0; i < 5; i++) push({3'b000, 8'h31});
    chk("R6 level 14 at 13", trig, 0);
    push({3'b000, 8'h32});
    chk("R6 level 14 at 14", trig, 1);
    ctl(8'h03);

    for (int i = 0; i < 16; i++) push({3'b000, 8'(8'h80 + i)});
    cyc(1, {3'b111, 8'hEE}, 0, 1, 0, 8'h00, 0);
    chk("R10 overrun set wins", ovr, 1);
    chk("R10 overrun head kept", rx_byte, 8'h80);
    chk("R3 discarded error not counted", any_err, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R10 contents kept", rx_byte, 8'(8'h80 + i));
      pop();
    end
    chk("R10 discarded byte absent", rdy, 0);
    chk("R10 overrun sticky", ovr, 1);
    cyc(0, '0, 0, 1, 0, 8'h00, 0);
    chk("R10 status read clears", ovr, 0);

    push({3'b000, 8'hA0});
    push({3'b000, 8'hA1});
    cyc(1, {3'b000, 8'hA2}, 1, 0, 0, 8'h00, 0);
    chk("R12 head advanced", rx_byte, 8'hA1);
    pop();
    chk("R12 third kept", rx_byte, 8'hA2);
    pop();
    chk("R12 level unchanged", rdy, 0);

    push({3'b000, 8'h55});
    push({3'b000, 8'h56});
    for (int i = 0; i < 3; i++) tick();
    chk("R8 three ticks", tmo, 0);
    tick();
    chk("R8 four ticks", tmo, 1);
    pop();
    chk("R9 read clears tmo", tmo, 0);
    for (int i = 0; i < 3; i++) tick();
    push({3'b000, 8'h57});
    for (int i = 0; i < 3; i++) tick();
    chk("R9 arrival restarts", tmo, 0);
    tick();
    chk("R8 fires after restart", tmo, 1);
    ctl(8'h03);
    chk("R9 flush drops tmo", tmo, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule